// File: doc/BRIEF.md
# Masked Interrupt Control Register

This block gathers single-cycle event pulses from five interrupt sources (first timer underflow, second timer underflow, time-of-day alarm, serial shift completion, external edge flag) into a latched flag register. A 5-bit enable mask decides which of those flags may raise the interrupt request. Software reaches the block through a small register port: one address, the control address (default 0xD), carries both the mask update on write and the flag readout on read.

Writes to the control address change the mask with a set/clear convention. Bit 7 of the written byte picks the operation, and bits 4:0 pick the mask bits it applies to. A read of the control address returns the flags with a summary bit in bit 7. On the clock edge that ends the read, all flags and the summary are cleared and the request is released. The request is raised once per pending episode. It can be raised by a source event or by a mask write that enables a flag already pending. It stays raised until a clearing read.

Top module: `int_ctrl_reg`

## Requirements
- R1: After reset the mask is all zero, the flags are all zero, the summary bit is clear and `irq_n_o` is high.
- R2: A pulse on `src_i[k]` sets flag bit k at the next clock edge, whether or not mask bit k is set. Flags accumulate until a clearing read. The bit assignment is: 0 first timer, 1 second timer, 2 alarm, 3 serial, 4 external flag.
- R3: A write to the control address with `wdata_i[7]`=1 ORs `wdata_i[4:0]` into the mask.
- R4: A write to the control address with `wdata_i[7]`=0 clears every mask bit whose matching `wdata_i[4:0]` bit is 1 and leaves the other mask bits unchanged.
- R5: When flags AND mask is nonzero, the summary bit is set and `irq_n_o` (active low, registered) is low from the clock edge that produced that condition.
- R6: A mask write that enables an already pending flag drives `irq_n_o` low at the edge that ends the write.
- R7: A read of the control address returns {summary, 2'b00, flags[4:0]} combinationally while `rd_i` is high. At the edge that ends the read, flags and summary clear and `irq_n_o` goes high, unless R8 applies.
- R8: A source pulse in the same cycle as a clearing read is kept. Its flag is set after the edge, and it raises the request if that source is enabled.
- R9: Writes to any other address leave the mask unchanged. Reads of any other address return 0 and clear nothing.
- R10: Once raised, the request stays low until a clearing read, even if more flags arrive or the mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 5 | Source event pulses, one bit per source |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The assertions assume each source bit is a clean, synchronous level sampled once per clock edge. They also assume a read or write lasts exactly one cycle, with its address stable in that cycle. The bench drives every input at the falling edge and holds every strobe and pulse for one full cycle. It also overlaps reads with pulses and writes with pending flags on purpose, so the collision cases the assertions single out are exercised within those assumptions.

// File: rtl/int_ctrl_pkg.sv
package int_ctrl_pkg;
  localparam int unsigned SRC_COUNT  = 5;
  localparam int unsigned REG_WIDTH  = 8;
  localparam int unsigned ADDR_WIDTH = 4;
  localparam logic [3:0]  CTL_OFFSET = 4'hD;

  typedef enum int unsigned {
    SRC_TMR0   = 0,
    SRC_TMR1   = 1,
    SRC_ALARM  = 2,
    SRC_SERIAL = 3,
    SRC_EXTFLG = 4
  } src_idx_e;
endpackage

// File: rtl/int_ctrl_decode.sv
module int_ctrl_decode #(
  parameter int unsigned     ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 'hD
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o
);
  logic addr_match;
  assign addr_match = (addr_i == CTL_ADDR);
  assign wr_hit_o   = wr_i & addr_match;
  assign rd_hit_o   = rd_i & addr_match;
endmodule

// File: rtl/int_ctrl_mask.sv
module int_ctrl_mask #(
  parameter int unsigned SRC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit_i,
  input  logic             set_mode_i,
  input  logic [SRC_W-1:0] sel_i,
  output logic [SRC_W-1:0] mask_q_o,
  output logic [SRC_W-1:0] mask_next_o
);
  function automatic logic [SRC_W-1:0] mask_update(
    input logic [SRC_W-1:0] cur,
    input logic             set_mode,
    input logic [SRC_W-1:0] sel
  );
    return set_mode ? (cur | sel) : (cur & ~sel);
  endfunction

  logic [SRC_W-1:0] mask_q;

  assign mask_next_o = wr_hit_i ? mask_update(mask_q, set_mode_i, sel_i) : mask_q;
  assign mask_q_o    = mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_next_o;
  end
endmodule

// File: rtl/int_ctrl_flags.sv
module int_ctrl_flags #(
  parameter int unsigned SRC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [SRC_W-1:0] src_i,
  output logic [SRC_W-1:0] flags_q_o,
  output logic [SRC_W-1:0] flags_next_o
);
  function automatic logic flag_step(
    input logic held,
    input logic clear,
    input logic event_in
  );
    return (held & ~clear) | event_in;
  endfunction

  logic [SRC_W-1:0] flags_q;

  for (genvar i = 0; i < SRC_W; i++) begin : g_flag
    assign flags_next_o[i] = flag_step(flags_q[i], clear_i, src_i[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_next_o;
  end

  assign flags_q_o = flags_q;
endmodule

// File: rtl/int_ctrl_req.sv
module int_ctrl_req #(
  parameter int unsigned SRC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [SRC_W-1:0] flags_next_i,
  input  logic [SRC_W-1:0] mask_next_i,
  output logic             summary_o,
  output logic             irq_n_o,
  output logic             req_fire_o
);
  function automatic logic summary_step(
    input logic             held,
    input logic             clear,
    input logic [SRC_W-1:0] flags,
    input logic [SRC_W-1:0] mask
  );
    return (held & ~clear) | (|(flags & mask));
  endfunction

  logic summary_q;
  logic summary_next;
  logic irq_n_q;

  assign summary_next = summary_step(summary_q, clear_i, flags_next_i, mask_next_i);
  assign req_fire_o   = summary_next & ~summary_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      summary_q <= 1'b0;
      irq_n_q   <= 1'b1;
    end else begin
      summary_q <= summary_next;
      irq_n_q   <= ~summary_next;
    end
  end

  assign summary_o = summary_q;
  assign irq_n_o   = irq_n_q;
endmodule

// File: rtl/int_ctrl_reg.sv
module int_ctrl_reg
  import int_ctrl_pkg::*;
#(
  parameter int unsigned       SRC_W    = SRC_COUNT,
  parameter int unsigned       DATA_W   = REG_WIDTH,
  parameter int unsigned       ADDR_W   = ADDR_WIDTH,
  parameter logic [ADDR_W-1:0] CTL_ADDR = CTL_OFFSET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_n_o
);
  localparam int unsigned SUM_BIT = DATA_W - 1;
  localparam int unsigned PAD_W   = DATA_W - 1 - SRC_W;

  logic             wr_hit;
  logic             rd_hit;
  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] mask_next;
  logic [SRC_W-1:0] flags_q;
  logic [SRC_W-1:0] flags_next;
  logic             summary_q;
  logic             req_fire;
  logic             wdata_unused;

  assign wdata_unused = &{1'b0, wdata_i[SUM_BIT-1:SRC_W]};

  int_ctrl_decode #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_decode (
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .wr_hit_o (wr_hit),
    .rd_hit_o (rd_hit)
  );

  int_ctrl_mask #(.SRC_W(SRC_W)) u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_hit_i    (wr_hit),
    .set_mode_i  (wdata_i[SUM_BIT]),
    .sel_i       (wdata_i[SRC_W-1:0]),
    .mask_q_o    (mask_q),
    .mask_next_o (mask_next)
  );

  int_ctrl_flags #(.SRC_W(SRC_W)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (rd_hit),
    .src_i        (src_i),
    .flags_q_o    (flags_q),
    .flags_next_o (flags_next)
  );

  int_ctrl_req #(.SRC_W(SRC_W)) u_req (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (rd_hit),
    .flags_next_i (flags_next),
    .mask_next_i  (mask_next),
    .summary_o    (summary_q),
    .irq_n_o      (irq_n_o),
    .req_fire_o   (req_fire)
  );

  assign rdata_o = rd_hit ? {summary_q, {PAD_W{1'b0}}, flags_q} : '0;
endmodule

// File: rtl/int_ctrl_chk.sv
module int_ctrl_chk #(
  parameter int unsigned SRC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_W-1:0] src_i,
  input logic             wr_hit,
  input logic             rd_hit,
  input logic             set_mode,
  input logic [SRC_W-1:0] sel,
  input logic [SRC_W-1:0] mask_q,
  input logic [SRC_W-1:0] flags_q,
  input logic             req_fire,
  input logic             irq_n_o
);
  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_i) |=> ((flags_q & $past(src_i)) == $past(src_i)));

  p_mask_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && set_mode) |=> ((mask_q & $past(sel)) == $past(sel)));

  p_mask_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !set_mode) |=> ((mask_q & $past(sel)) == '0));

  p_pending_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(flags_q & mask_q)) && !rd_hit) |=> !irq_n_o);

  p_enable_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && set_mode && (|(flags_q & sel)) && !rd_hit) |=> !irq_n_o);

  p_read_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && (src_i == '0) && !wr_hit) |=> (irq_n_o && (flags_q == '0)));

  p_collision_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (flags_q == $past(src_i)));

  p_collision_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !wr_hit && (|(src_i & mask_q))) |=> !irq_n_o);

  p_mask_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(mask_q));

  p_hold_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !rd_hit) |=> !irq_n_o);

  p_single_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !rd_hit) |-> !req_fire);
endmodule

bind int_ctrl_reg int_ctrl_chk #(.SRC_W(SRC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_i    (src_i),
  .wr_hit   (wr_hit),
  .rd_hit   (rd_hit),
  .set_mode (wdata_i[DATA_W-1]),
  .sel      (wdata_i[SRC_W-1:0]),
  .mask_q   (mask_q),
  .flags_q  (flags_q),
  .req_fire (req_fire),
  .irq_n_o  (irq_n_o)
);

// File: tb/test_int_ctrl_reg.sv
`timescale 1ns/1ps
module test_int_ctrl_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] src = '0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [3:0] CTL = 4'hD;

  always #2.5 clk = ~clk;

  int_ctrl_reg i_int_ctrl_reg (
    .clk (clk), .rst_n (rst_n), .src_i (src), .addr_i (addr),
    .wr_i (wr), .rd_i (rd), .wdata_i (wdata), .rdata_o (rdata), .irq_n_o (irq_n)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [3:0] a, input logic [4:0] p,
                          input logic [7:0] exp, input string tag);
    addr = a; rd = 1'b1; src = p;
    #1;
    check(rdata, exp, tag);
    tick();
    rd = 1'b0; src = '0;
  endtask

  task automatic pulse(input logic [4:0] p);
    src = p;
    tick();
    src = '0;
  endtask

  function automatic logic [7:0] expect_read(input logic [4:0] fl, input logic [4:0] m);
    return {(fl & m) != 5'd0, 2'b00, fl};
  endfunction

  initial begin
    @(negedge clk);
    repeat (3) tick();
    check({7'd0, irq_n}, 8'h01, "R1 irq_n during reset");
    rst_n = 1'b1;
    tick();
    check({7'd0, irq_n}, 8'h01, "R1 irq_n after reset");
    reg_read(CTL, 5'd0, 8'h00, "R1 flags clear");
    pulse(5'h1F);
    check({7'd0, irq_n}, 8'h01, "R1 mask clear after reset");
    reg_read(CTL, 5'd0, 8'h1F, "R2 flags set while masked");

    pulse(5'h01);
    pulse(5'h08);
    reg_read(CTL, 5'd0, 8'h09, "R2 flags accumulate");

    for (int m = 0; m < 32; m++) begin
      for (int p = 1; p < 32; p++) begin
        reg_write(CTL, 8'h1F);
        reg_write(CTL, 8'h80 | 8'(m));
        reg_read(CTL, 5'd0, expect_read(5'd0, 5'(m)), "R7 pre-clear");
        pulse(5'(p));
        check({7'd0, irq_n}, {7'd0, (5'(p) & 5'(m)) == 5'd0}, "R3/R5 irq vs mask");
        reg_read(CTL, 5'd0, expect_read(5'(p), 5'(m)), "R5/R7 read value");
        check({7'd0, irq_n}, 8'h01, "R7 release after read");
      end
    end

    for (int c = 0; c < 32; c++) begin
      reg_write(CTL, 8'h9F);
      reg_write(CTL, 8'(c));
      pulse(5'h1F);
      check({7'd0, irq_n}, {7'd0, (~5'(c)) == 5'd0}, "R4 clear leaves others");
      reg_read(CTL, 5'd0, expect_read(5'h1F, ~5'(c)), "R4 read value");
    end

    reg_write(CTL, 8'h1F);
    pulse(5'h04);
    check({7'd0, irq_n}, 8'h01, "R6 pending but masked");
    reg_write(CTL, 8'h84);
    check({7'd0, irq_n}, 8'h00, "R6 enable raises request");
    reg_read(CTL, 5'd0, 8'h84, "R6 read value");

    reg_write(CTL, 8'h1F);
    reg_write(CTL, 8'h81);
    pulse(5'h01);
    check({7'd0, irq_n}, 8'h00, "R10 raised");
    pulse(5'h02);
    check({7'd0, irq_n}, 8'h00, "R10 held on new flag");
    reg_write(CTL, 8'h01);
    check({7'd0, irq_n}, 8'h00, "R10 held after mask clear");
    reg_read(CTL, 5'd0, 8'h83, "R10 read value");
    check({7'd0, irq_n}, 8'h01, "R10 released by read");

    reg_write(CTL, 8'h1F);
    reg_write(CTL, 8'h82);
    pulse(5'h01);
    reg_read(CTL, 5'h02, 8'h01, "R8 read during pulse");
    check({7'd0, irq_n}, 8'h00, "R8 enabled collision raises");
    reg_read(CTL, 5'd0, 8'h82, "R8 kept enabled flag");
    reg_write(CTL, 8'h1F);
    pulse(5'h01);
    reg_read(CTL, 5'h04, 8'h01, "R8 read during masked pulse");
    check({7'd0, irq_n}, 8'h01, "R8 masked collision quiet");
    reg_read(CTL, 5'd0, 8'h04, "R8 kept masked flag");

    for (int a = 0; a < 16; a++) begin
      if (a != 13) reg_write(4'(a), 8'h9F);
    end
    pulse(5'h1F);
    check({7'd0, irq_n}, 8'h01, "R9 other writes ignored");
    for (int a = 0; a < 16; a++) begin
      if (a != 13) reg_read(4'(a), 5'd0, 8'h00, "R9 other read zero");
    end
    reg_read(CTL, 5'd0, 8'h1F, "R9 other reads did not clear");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end
endmodule